// File: doc/BRIEF.md
# MPEG Transport Sync Frame Aligner

The block sits after a symbol-to-byte mapper and watches a stream of bytes, each qualified by a valid strobe. It hunts for MPEG transport sync bytes, accepting both the plain value 0x47 and its bit-inverted form 0xB8. It declares frame lock once enough correctly spaced sync bytes have been seen in a row. Frames are 204 valid bytes long: 188 payload bytes and 16 parity bytes. While locked it tracks frame boundaries and keeps lock through isolated damaged sync bytes. It drops lock after enough consecutive misses and then hunts again.

The bytes leave the block one cycle later, together with a one-byte frame-start pulse on each boundary byte, a flag that marks boundary bytes carrying the inverted sync value, and a frame-lock status flag. Two 4-bit thresholds are loaded through a small parallel write port. The acquisition threshold is the number of spaced sync bytes needed for lock. The loss threshold is the number of consecutive missed boundaries that ends lock. The block latches both values when a new hunt starts, so the values in force for a candidate or a locked frame train never change under it.

Top module: `mpeg_sync_aligner`

## Requirements
- R1: After a clock edge with `rst_n` low, `frame_lock`, `out_valid`, `frame_start` and `sync_inv` are 0. The acquisition register resets to 4 and the loss register resets to 3.
- R2: Every byte accepted with `in_valid` high appears on `out_byte` one clock later, with `out_valid` high.
- R3: A byte counts as a sync byte when it equals 0x47 or 0xB8. `sync_inv` is 1 only together with `frame_start`, and only when that boundary byte is 0xB8.
- R4: From hunting, `frame_lock` rises with the output of the sync byte that completes the acquisition count (a register value of 0 acts as 1). The count uses consecutive sync bytes, each exactly 204 valid bytes after the previous one. `frame_start` is high on that same byte.
- R5: While lock holds, `frame_start` is high for exactly one output byte at each frame boundary, every 204 valid bytes. This includes a boundary whose sync byte is missing but does not yet end lock. `frame_start` is never high on other bytes, and never without `out_valid`.
- R6: `frame_lock` falls with the output of the boundary byte that is the loss-threshold-th consecutive miss (a value of 0 acts as 1). `frame_start` is 0 on that byte. The next sync byte then starts a new hunt.
- R7: While a candidate is being confirmed, a non-sync byte at the expected boundary abandons the candidate. Sync values at other positions have no effect, both while confirming and while locked.
- R8: A threshold write (`cfg_sel` 0 selects acquisition, 1 selects loss) takes effect only at the next hunt restart. A write in the same cycle as the restarting sync byte is applied to that restart.
- R9: A cycle with `in_valid` low does not advance the frame position. `out_valid` is 0 in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Threshold register write strobe |
| cfg_sel | input | 1 | Register select: 0 acquisition, 1 loss |
| cfg_data | input | 4 | Threshold value to write |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Demodulated byte |
| out_valid | output | 1 | Output byte strobe, one cycle after input |
| out_byte | output | 8 | Delayed byte |
| frame_start | output | 1 | High on the boundary byte of each locked frame |
| sync_inv | output | 1 | Boundary byte carries the inverted sync value |
| frame_lock | output | 1 | Frame lock status |

## Verification
A threshold write and a hunt restart can fall in the same cycle, because a write may arrive together with the sync byte that opens a new candidate. The bench provokes this by holding the write strobe high with acquisition value 1 during that very sync byte, while the register still holds 4. It then requires lock on that byte. A second case writes during confirmation, and the bench requires that this write changes nothing until the next restart.

// File: rtl/aligner_pkg.sv
// Package: shared types for the sync frame aligner.
// Assumes: single clock domain; used by all aligner submodules.
package aligner_pkg;

    // Tracking state of the frame aligner.
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_TRACK   = 2'd2
    } align_state_t;

    // Register select codes of the parallel threshold port.
    localparam logic SEL_ACQ  = 1'b0;
    localparam logic SEL_LOSS = 1'b1;

endpackage

// File: rtl/aligner_sync_match.sv
// Module: aligner_sync_match
// Compares the incoming byte with the plain sync value and, when enabled
// by ACCEPT_INV, with its bitwise inverse. Purely combinational.
// Assumes: in_byte is only meaningful when qualified by the caller.
module aligner_sync_match #(
    parameter logic [7:0] SYNC_BYTE  = 8'h47,
    parameter bit         ACCEPT_INV = 1'b1
) (
    input  logic [7:0] in_byte,
    output logic       is_norm,
    output logic       is_inv
);

    localparam logic [7:0] INV_BYTE = ~SYNC_BYTE;

    // Plain-polarity comparison.
    assign is_norm = (in_byte == SYNC_BYTE);

    generate
        if (ACCEPT_INV) begin : g_inv
            // Inverted-polarity comparison.
            assign is_inv = (in_byte == INV_BYTE);
        end else begin : g_no_inv
            assign is_inv = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/aligner_cfg.sv
// Module: aligner_cfg
// Holds the programmable acquisition and loss thresholds and the copies
// that are in force for the current hunt. The in-force copies are loaded
// only when a hunt restarts. A write in the restart cycle is forwarded.
// A zero threshold is floored to one.
// Assumes: restart is a single-cycle strobe from the tracker.
module aligner_cfg
    import aligner_pkg::*;
#(
    parameter int THR_W    = 4,
    parameter int ACQ_RST  = 4,
    parameter int LOSS_RST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [THR_W-1:0] cfg_data,
    input  logic             restart,
    output logic [THR_W-1:0] acq_start,
    output logic [THR_W-1:0] acq_hold,
    output logic [THR_W-1:0] loss_hold
);

    localparam logic [THR_W-1:0] ONE = THR_W'(1);

    logic [THR_W-1:0] acq_reg, loss_reg;
    logic [THR_W-1:0] acq_fwd, loss_fwd;
    logic [THR_W-1:0] acq_flr, loss_flr;

    // Forward a same-cycle write so that a restart sees it.
    always_comb begin
        acq_fwd  = (cfg_wr && cfg_sel == SEL_ACQ)  ? cfg_data : acq_reg;
        loss_fwd = (cfg_wr && cfg_sel == SEL_LOSS) ? cfg_data : loss_reg;
        acq_flr  = (acq_fwd  == '0) ? ONE : acq_fwd;
        loss_flr = (loss_fwd == '0) ? ONE : loss_fwd;
    end

    assign acq_start = acq_flr;

    // Programmable threshold registers written through the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_reg  <= THR_W'(ACQ_RST);
            loss_reg <= THR_W'(LOSS_RST);
        end else if (cfg_wr) begin
            if (cfg_sel == SEL_ACQ) acq_reg  <= cfg_data;
            else                    loss_reg <= cfg_data;
        end
    end

    // In-force copies, refreshed only at a hunt restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_hold  <= (ACQ_RST == 0)  ? ONE : THR_W'(ACQ_RST);
            loss_hold <= (LOSS_RST == 0) ? ONE : THR_W'(LOSS_RST);
        end else if (restart) begin
            acq_hold  <= acq_flr;
            loss_hold <= loss_flr;
        end
    end

endmodule

// File: rtl/aligner_track.sv
// Module: aligner_track
// Frame position tracker and lock state machine. It counts valid bytes
// since the last boundary, counts confirmed sync bytes while acquiring and
// consecutive misses while locked, and flags boundary bytes that carry a
// frame-start marker.
// Assumes: thresholds are already floored to at least one.
module aligner_track
    import aligner_pkg::*;
#(
    parameter int FRAME_LEN = 204,
    parameter int THR_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             is_norm,
    input  logic             is_inv,
    input  logic [THR_W-1:0] acq_start,
    input  logic [THR_W-1:0] acq_hold,
    input  logic [THR_W-1:0] loss_hold,
    output logic             restart,
    output logic             mark_next,
    output logic             inv_next,
    output logic             locked
);

    localparam int POS_W = $clog2(FRAME_LEN + 1);
    localparam logic [POS_W-1:0] POS_EDGE  = POS_W'(FRAME_LEN);
    localparam logic [POS_W-1:0] POS_FIRST = POS_W'(1);

    align_state_t     state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic [THR_W-1:0] hits_q, hits_d;
    logic [THR_W-1:0] miss_q, miss_d;
    logic [THR_W:0]   hits_inc, miss_inc;
    logic             is_sync, at_edge;

    assign is_sync  = is_norm | is_inv;
    assign at_edge  = (pos_q == POS_EDGE);
    assign hits_inc = {1'b0, hits_q} + 1'b1;
    assign miss_inc = {1'b0, miss_q} + 1'b1;
    assign restart  = in_valid && (state_q == ST_HUNT) && is_sync;
    assign inv_next = mark_next && is_inv;
    assign locked   = (state_q == ST_TRACK);

    // Next-state, counter and marker decisions for one input cycle.
    always_comb begin
        state_d   = state_q;
        pos_d     = pos_q;
        hits_d    = hits_q;
        miss_d    = miss_q;
        mark_next = 1'b0;
        if (in_valid) begin
            case (state_q)
                ST_HUNT: begin
                    if (is_sync) begin
                        pos_d  = POS_FIRST;
                        hits_d = THR_W'(1);
                        miss_d = '0;
                        if (acq_start == THR_W'(1)) begin
                            state_d   = ST_TRACK;
                            mark_next = 1'b1;
                        end else begin
                            state_d = ST_CONFIRM;
                        end
                    end
                end
                ST_CONFIRM: begin
                    if (at_edge) begin
                        pos_d = POS_FIRST;
                        if (is_sync) begin
                            hits_d = hits_inc[THR_W-1:0];
                            if (hits_inc >= {1'b0, acq_hold}) begin
                                state_d   = ST_TRACK;
                                miss_d    = '0;
                                mark_next = 1'b1;
                            end
                        end else begin
                            state_d = ST_HUNT;
                        end
                    end else begin
                        pos_d = pos_q + 1'b1;
                    end
                end
                ST_TRACK: begin
                    if (at_edge) begin
                        pos_d = POS_FIRST;
                        if (is_sync) begin
                            miss_d    = '0;
                            mark_next = 1'b1;
                        end else if (miss_inc >= {1'b0, loss_hold}) begin
                            state_d = ST_HUNT;
                            miss_d  = '0;
                        end else begin
                            miss_d    = miss_inc[THR_W-1:0];
                            mark_next = 1'b1;
                        end
                    end else begin
                        pos_d = pos_q + 1'b1;
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            hits_q  <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            hits_q  <= hits_d;
            miss_q  <= miss_d;
        end
    end

endmodule

// File: rtl/mpeg_sync_aligner.sv
// Module: mpeg_sync_aligner (top)
// Finds MPEG transport frame boundaries in a byte stream by their sync
// byte (plain or inverted), acquires and holds frame lock under
// programmable thresholds, and outputs the stream one cycle later with
// frame-start and inverted-sync markers.
// Assumes: one byte per cycle at most, qualified by in_valid.
module mpeg_sync_aligner #(
    parameter int         FRAME_LEN  = 204,
    parameter logic [7:0] SYNC_BYTE  = 8'h47,
    parameter bit         ACCEPT_INV = 1'b1,
    parameter int         THR_W      = 4,
    parameter int         ACQ_RST    = 4,
    parameter int         LOSS_RST   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [THR_W-1:0] cfg_data,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             frame_start,
    output logic             sync_inv,
    output logic             frame_lock
);

    logic             is_norm, is_inv, restart, mark_next, inv_next;
    logic [THR_W-1:0] acq_start, acq_hold, loss_hold;

    aligner_sync_match #(
        .SYNC_BYTE  (SYNC_BYTE),
        .ACCEPT_INV (ACCEPT_INV)
    ) u_match (
        .in_byte (in_byte),
        .is_norm (is_norm),
        .is_inv  (is_inv)
    );

    aligner_cfg #(
        .THR_W    (THR_W),
        .ACQ_RST  (ACQ_RST),
        .LOSS_RST (LOSS_RST)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .restart   (restart),
        .acq_start (acq_start),
        .acq_hold  (acq_hold),
        .loss_hold (loss_hold)
    );

    aligner_track #(
        .FRAME_LEN (FRAME_LEN),
        .THR_W     (THR_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .is_norm   (is_norm),
        .is_inv    (is_inv),
        .acq_start (acq_start),
        .acq_hold  (acq_hold),
        .loss_hold (loss_hold),
        .restart   (restart),
        .mark_next (mark_next),
        .inv_next  (inv_next),
        .locked    (frame_lock)
    );

    // Output stage: one-cycle delay of the byte and its markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_byte    <= '0;
            frame_start <= 1'b0;
            sync_inv    <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_byte    <= in_valid ? in_byte : out_byte;
            frame_start <= mark_next;
            sync_inv    <= inv_next;
        end
    end

endmodule

// File: rtl/mpeg_sync_aligner_chk.sv
// Module: mpeg_sync_aligner_chk
// Port-level properties of the aligner, attached to every instance of the
// top module by the bind statement at the end of this file.
module mpeg_sync_aligner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       out_valid,
    input logic [7:0] out_byte,
    input logic       frame_start,
    input logic       sync_inv,
    input logic       frame_lock
);

    assert_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_byte == $past(in_byte)));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_inv_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_inv |-> (frame_start && out_byte == 8'hB8));

    assert_mark_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (out_valid && frame_lock));

    assert_lock_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_lock) |-> frame_start);

    assert_drop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_lock) |-> (out_valid && !frame_start));

endmodule

bind mpeg_sync_aligner mpeg_sync_aligner_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .out_valid   (out_valid),
    .out_byte    (out_byte),
    .frame_start (frame_start),
    .sync_inv    (sync_inv),
    .frame_lock  (frame_lock)
);

// File: tb/sim_mpeg_sync_aligner.sv
// Bench for mpeg_sync_aligner: a scenario table walked by one loop, then
// directed tests for reset and corner cases.
module sim_mpeg_sync_aligner;

    localparam int CLK_PERIOD = 10;
    localparam int FLEN       = 204;
    localparam int NTAB       = 5;
    // Entry: {acquisition value[3:0], inverted sync[0], expected lock frame[3:0]}
    localparam logic [8:0] TAB [NTAB] = '{
        {4'd1, 1'b0, 4'd1},
        {4'd2, 1'b1, 4'd2},
        {4'd3, 1'b0, 4'd3},
        {4'd0, 1'b1, 4'd1},
        {4'd4, 1'b1, 4'd4}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [3:0] cfg_data = '0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       out_valid, frame_start, sync_inv, frame_lock;
    logic [7:0] out_byte;

    int  nchk = 0;
    int  nerr = 0;
    bit  done = 1'b0;
    logic       o_valid, o_fs, o_inv, o_lock;
    logic [7:0] o_byte;
    logic       s_fs, s_inv, s_lock;
    bit         mid_fs;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpeg_sync_aligner u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte), .frame_start(frame_start),
        .sync_inv(sync_inv), .frame_lock(frame_lock)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle (called at a falling edge), sample after the rise.
    task automatic push(input logic [7:0] b, input logic v);
        in_valid = v;
        in_byte  = b;
        @(posedge clk);
        #1;
        o_valid = out_valid; o_byte = out_byte; o_fs = frame_start;
        o_inv = sync_inv; o_lock = frame_lock;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr_cfg(input logic sel, input logic [3:0] d);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
        push(8'h00, 1'b0);
        cfg_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        push(8'h00, 1'b0);
        push(8'h00, 1'b0);
        rst_n = 1'b1;
    endtask

    // One frame: boundary byte, then 203 fillers (values 0..63, never sync).
    task automatic send_frame(input logic [7:0] sb, input bit gap, input bit extra);
        push(sb, 1'b1);
        s_fs = o_fs; s_inv = o_inv; s_lock = o_lock;
        mid_fs = 1'b0;
        for (int i = 1; i < FLEN; i++) begin
            if (gap && i == 100) begin
                push(8'h47, 1'b0);
                push(8'h47, 1'b0);
            end
            push((extra && i == 50) ? 8'h47 : 8'(i % 64), 1'b1);
            if (o_fs) mid_fs = 1'b1;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk(o_lock == 1'b0, "R1 lock", o_lock, 0);
        chk(o_valid == 1'b0, "R1 out_valid", o_valid, 0);
        chk(o_fs == 1'b0 && o_inv == 1'b0, "R1 markers", o_fs, 0);

        // R2 / R9: byte delay and idle cycle
        push(8'h5A, 1'b1);
        chk(o_valid && o_byte == 8'h5A, "R2 delayed byte", o_byte, 8'h5A);
        push(8'h33, 1'b0);
        chk(o_valid == 1'b0, "R9 idle out_valid", o_valid, 0);

        // R4 / R3: table of acquisition scenarios
        for (int t = 0; t < NTAB; t++) begin
            int lock_at;
            logic [7:0] sb;
            logic fs_at, inv_at;
            lock_at = 0; fs_at = 1'b0; inv_at = 1'b0;
            sb = TAB[t][4] ? 8'hB8 : 8'h47;
            do_reset();
            wr_cfg(1'b0, TAB[t][8:5]);
            for (int f = 1; f <= 6; f++) begin
                send_frame(sb, 1'b0, 1'b0);
                if (s_lock && lock_at == 0) begin
                    lock_at = f; fs_at = s_fs; inv_at = s_inv;
                end
            end
            chk(lock_at == int'(TAB[t][3:0]), "R4 lock frame", lock_at, TAB[t][3:0]);
            chk(fs_at == 1'b1, "R4 frame_start at lock", fs_at, 1);
            chk(inv_at == TAB[t][4], "R3 sync_inv at lock", inv_at, TAB[t][4]);
        end

        // R9: idle cycles inside a frame do not shift the boundary
        do_reset();
        wr_cfg(1'b0, 4'd2);
        send_frame(8'h47, 1'b1, 1'b0);
        send_frame(8'h47, 1'b0, 1'b0);
        chk(s_lock == 1'b1, "R9 lock across idle gap", s_lock, 1);

        // R5: flywheel through a missing sync, no mid-frame marks
        chk(mid_fs == 1'b0, "R5 no mid-frame start", mid_fs, 0);
        send_frame(8'h00, 1'b0, 1'b0);
        chk(s_fs && s_lock, "R5 start on missed boundary", {s_fs, s_lock}, 3);
        chk(s_inv == 1'b0, "R3 no inv on missed boundary", s_inv, 0);
        send_frame(8'h47, 1'b0, 1'b0);
        chk(s_fs == 1'b1, "R5 start on next boundary", s_fs, 1);

        // R6: lock loss after consecutive misses, then a new hunt
        do_reset();
        wr_cfg(1'b0, 4'd1);
        wr_cfg(1'b1, 4'd2);
        send_frame(8'h47, 1'b0, 1'b0);
        chk(s_lock == 1'b1, "R6 initial lock", s_lock, 1);
        send_frame(8'h00, 1'b0, 1'b0);
        chk(s_lock == 1'b1, "R6 one miss keeps lock", s_lock, 1);
        send_frame(8'h00, 1'b0, 1'b0);
        chk(s_lock == 1'b0 && s_fs == 1'b0, "R6 drop on second miss", {s_lock, s_fs}, 0);
        send_frame(8'hB8, 1'b0, 1'b0);
        chk(s_lock == 1'b1 && s_inv == 1'b1, "R6 relock after hunt", {s_lock, s_inv}, 3);

        // R7: stray sync inside a frame is ignored while confirming
        do_reset();
        wr_cfg(1'b0, 4'd3);
        send_frame(8'h47, 1'b0, 1'b1);
        send_frame(8'h47, 1'b0, 1'b1);
        chk(s_lock == 1'b0, "R7 no early lock", s_lock, 0);
        send_frame(8'h47, 1'b0, 1'b0);
        chk(s_lock == 1'b1, "R7 lock on third", s_lock, 1);
        send_frame(8'h47, 1'b0, 1'b1);
        send_frame(8'h47, 1'b0, 1'b0);
        chk(s_fs && !mid_fs, "R7 stray sync ignored in lock", {s_fs, mid_fs}, 2);

        // R7: bad boundary abandons the candidate
        do_reset();
        wr_cfg(1'b0, 4'd2);
        send_frame(8'h47, 1'b0, 1'b0);
        send_frame(8'h00, 1'b0, 1'b0);
        send_frame(8'h47, 1'b0, 1'b0);
        chk(s_lock == 1'b0, "R7 candidate abandoned", s_lock, 0);
        send_frame(8'h47, 1'b0, 1'b0);
        chk(s_lock == 1'b1, "R7 lock after new candidate", s_lock, 1);

        // R8: write while locked is deferred
        do_reset();
        wr_cfg(1'b0, 4'd1);
        send_frame(8'h47, 1'b0, 1'b0);
        wr_cfg(1'b1, 4'd1);
        send_frame(8'h00, 1'b0, 1'b0);
        chk(s_lock == 1'b1, "R8 loss write deferred", s_lock, 1);

        // R8: write while confirming is deferred
        do_reset();
        wr_cfg(1'b0, 4'd3);
        send_frame(8'h47, 1'b0, 1'b0);
        wr_cfg(1'b0, 4'd1);
        send_frame(8'h47, 1'b0, 1'b0);
        chk(s_lock == 1'b0, "R8 acq write deferred", s_lock, 0);

        // R8: write in the same cycle as the restart byte is applied
        do_reset();
        cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_data = 4'd1;
        push(8'h47, 1'b1);
        cfg_wr = 1'b0;
        chk(o_lock == 1'b1 && o_fs == 1'b1, "R8 same-cycle write", {o_lock, o_fs}, 3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule